// File: doc/BRIEF.md
# Fuse-Map Address Sequencer

This block walks the array-configuration bits of one programmable-logic function block in the order a serial configuration file lists them. For each bit it produces the physical coordinate of that fuse: array row, plane and column. It covers four kinds of bit: the input-multiplexer selects, the AND-array true/complement literals of every product term, the product-term feedback literals, and the OR-array sum connections.

A host pulses `start_i` with the block's index, its block-row base, the start columns of the mux and product-term regions and the mux field width. The sequencer captures these values and then presents one coordinate per cycle under a valid/ready handshake. A coordinate is consumed only when valid and ready are both high. After the final sum bit is consumed it raises a one-cycle done flag. Each block row spans 52 array rows. The two array rows that follow all block rows are never produced.

Mapping rules. Input or mux index j lands on array row `base*52 + 2 + j`, with 8 further rows added once j reaches 20. Odd-indexed blocks mirror their product-term columns about a span of 95. The eight feedback literals use their own row/plane pairs.

Top module: `fuse_addr_seq`

## Requirements
- R1: After reset, `coord_valid_o` and `done_o` are both low until a start is accepted.
- R2: Beats 0 .. 40*W-1 (W = mux width) cover mux index j = 0..39, outer, and bit k = 0..W-1, inner. Each is at column `mux_col + W - 1 - k` on plane 1 for an even block index and plane 0 for an odd one. The row is `base*52 + 2 + j` for j < 20.
- R3: Every row derived from an input or mux index j with j >= 20 is `base*52 + 10 + j`.
- R4: Next come product terms p = 0..47. For each input i = 0..39, a true literal on plane 0 is followed by a complement literal on plane 1, both on the input row of R2/R3. The column is `pt_col + p` for even blocks and `pt_col + 95 - p` for odd blocks.
- R5: After the 80 literals of product term p come feedback literals f = 0..7, in the same column as R4. Their (row offset from `base*52`, plane) pairs are: 0:(0,1), 1:(0,0), 2:(1,1), 3:(1,0), 4:(50,0), 5:(50,1), 6:(51,0), 7:(51,1).
- R6: Last come product terms p = 0..47 with macrocells m = 0..15 inner. Each is at row `base*52 + 22 + m/2` and plane `1 - (m mod 2)`, with the column of R4.
- R7: A full sequence is exactly 40*W + 4992 accepted beats in the order of R2..R6.
- R8: While `coord_valid_o` is high and `coord_ready_i` is low, the coordinate holds and valid stays high. The position advances only on an accepted beat.
- R9: `done_o` is high for exactly the one cycle after the last sum beat is accepted, and valid is low in that cycle.
- R10: A start pulse during a sequence has no effect: the running sequence continues with its captured configuration.
- R11: With W = 0 the mux bits are skipped and the first beat is the first true literal of product term 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| blk_idx_i | input | IDX_W | Function-block index; bit 0 selects mirroring and mux plane |
| row_base_i | input | BASE_W | Block-row number of the function block |
| mux_col_i | input | COL_W | First column of the mux region |
| pt_col_i | input | COL_W | First column of the product-term region |
| mux_width_i | input | WID_W | Bits per input-mux field |
| coord_ready_i | input | 1 | Consumer accepts the current coordinate |
| coord_valid_o | output | 1 | A coordinate is presented |
| coord_row_o | output | ROW_W | Array row |
| coord_plane_o | output | 1 | Array plane |
| coord_col_o | output | COL_W | Array column |
| done_o | output | 1 | One-cycle pulse after the last beat |

## Verification
Two events can coincide with a beat boundary. A start pulse can land in a cycle where a beat is accepted or held. The final sum beat can be accepted in the same cycle that done would be judged. The bench drives a differing start configuration in the middle of a randomly back-pressured run. Every later beat must still match the model built from the original configuration. Done is checked to stay low through every earlier beat, to be high exactly one cycle after the last acceptance with valid low, and to be low again on the following cycle.

// File: rtl/fuse_seq_pkg.sv
// Package: shared phase encoding and fixed geometry of one function block.
// Assumes the array geometry constants below are common to every device size.
package fuse_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_IMUX = 2'd1,
        PH_PTRM = 2'd2,
        PH_SUMT = 2'd3
    } phase_t;

    localparam int BLK_ROWS_D  = 52;
    localparam int N_INPUTS_D  = 40;
    localparam int N_FBK_D     = 8;
    localparam int N_PTERM_D   = 48;
    localparam int N_MCELL_D   = 16;
    localparam int MUX_OFS_D   = 2;
    localparam int GAP_IDX_D   = 20;
    localparam int GAP_ROWS_D  = 8;
    localparam int SUM_OFS_D   = 22;
    localparam int MIRROR_D    = 95;
endpackage

// File: rtl/fseq_walker.sv
// Module: index walker. Holds the phase and the outer/inner/literal counters
// and steps them on each accepted beat, in file order. Assumes width_q_i is
// stable for the whole sequence (captured by the parent at start).
module fseq_walker
    import fuse_seq_pkg::*;
#(
    parameter int N_INPUTS = N_INPUTS_D,
    parameter int N_FBK    = N_FBK_D,
    parameter int N_PTERM  = N_PTERM_D,
    parameter int N_MCELL  = N_MCELL_D,
    parameter int WID_W    = 5,
    parameter int OUT_W    = 6,
    parameter int CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok_i,
    input  logic             skip_mux_i,
    input  logic [WID_W-1:0] width_q_i,
    input  logic             accept_i,
    output phase_t           phase_o,
    output logic [OUT_W-1:0] outer_o,
    output logic [CNT_W-1:0] inner_o,
    output logic             neg_o,
    output logic             done_o
);
    localparam int PT_SPAN = N_INPUTS + N_FBK;

    phase_t           phase_q;
    logic [OUT_W-1:0] outer_q;
    logic [CNT_W-1:0] inner_q;
    logic             neg_q;
    logic             done_q;

    logic [CNT_W-1:0] inner_lim;
    logic [OUT_W-1:0] outer_lim;
    logic             step_inner;
    logic             inner_end;
    logic             outer_end;
    logic             last_beat;
    phase_t           phase_nx;

    // Purpose: loop limits and the follow-on phase for the current phase.
    always_comb begin
        inner_lim = '0;
        outer_lim = OUT_W'(N_PTERM - 1);
        phase_nx  = PH_IDLE;
        unique case (phase_q)
            PH_IMUX: begin
                inner_lim = CNT_W'(width_q_i) - CNT_W'(1);
                outer_lim = OUT_W'(N_INPUTS - 1);
                phase_nx  = PH_PTRM;
            end
            PH_PTRM: begin
                inner_lim = CNT_W'(PT_SPAN - 1);
                phase_nx  = PH_SUMT;
            end
            PH_SUMT: begin
                inner_lim = CNT_W'(N_MCELL - 1);
                phase_nx  = PH_IDLE;
            end
            default: ;
        endcase
    end

    // Purpose: decide whether this beat moves the inner index or only the literal bit.
    always_comb begin
        step_inner = (phase_q != PH_PTRM) || (inner_q >= CNT_W'(N_INPUTS)) || neg_q;
        inner_end  = (inner_q == inner_lim);
        outer_end  = (outer_q == outer_lim);
        last_beat  = (phase_q == PH_SUMT) && inner_end && outer_end;
    end

    // Purpose: phase and counter registers, advanced only on accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            outer_q <= '0;
            inner_q <= '0;
            neg_q   <= 1'b0;
        end else if (start_ok_i) begin
            phase_q <= skip_mux_i ? PH_PTRM : PH_IMUX;
            outer_q <= '0;
            inner_q <= '0;
            neg_q   <= 1'b0;
        end else if (accept_i && phase_q != PH_IDLE) begin
            if (!step_inner) begin
                neg_q <= 1'b1;
            end else begin
                neg_q <= 1'b0;
                if (!inner_end) begin
                    inner_q <= inner_q + CNT_W'(1);
                end else begin
                    inner_q <= '0;
                    if (!outer_end) begin
                        outer_q <= outer_q + OUT_W'(1);
                    end else begin
                        outer_q <= '0;
                        phase_q <= phase_nx;
                    end
                end
            end
        end
    end

    // Purpose: one-cycle done pulse after the final sum beat is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= accept_i && last_beat;
    end

    assign phase_o = phase_q;
    assign outer_o = outer_q;
    assign inner_o = inner_q;
    assign neg_o   = neg_q;
    assign done_o  = done_q;
endmodule

// File: rtl/fseq_fbk_map.sv
// Module: feedback-literal placement. Maps feedback index k to a row offset
// inside the block row and a plane. The first half of the literals sits in
// the two top rows, the second half in the two bottom rows of the block row.
// Assumes N_FBK is a multiple of 4.
module fseq_fbk_map #(
    parameter int BLK_ROWS = 52,
    parameter int N_FBK    = 8,
    parameter int FB_W     = 3,
    parameter int DR_W     = 6
) (
    input  logic [FB_W-1:0] fbk_i,
    output logic [DR_W-1:0] dr_o,
    output logic            plane_o
);
    localparam int HALF = N_FBK / 2;
    localparam int LOW_ROW = BLK_ROWS - 2;

    logic upper_half;

    // Purpose: pair literals two per row; top half starts on plane 1, bottom on plane 0.
    always_comb begin
        upper_half = (fbk_i < FB_W'(HALF));
        if (upper_half) begin
            dr_o    = DR_W'(fbk_i >> 1);
            plane_o = ~fbk_i[0];
        end else begin
            dr_o    = DR_W'(LOW_ROW) + DR_W'((fbk_i - FB_W'(HALF)) >> 1);
            plane_o = fbk_i[0];
        end
    end
endmodule

// File: rtl/fseq_coord.sv
// Module: coordinate generator. Purely combinational translation of the
// walker position and the captured configuration into (row, plane, column).
// Assumes configuration inputs are the registered copies held by the parent.
module fseq_coord
    import fuse_seq_pkg::*;
#(
    parameter int BLK_ROWS = BLK_ROWS_D,
    parameter int N_INPUTS = N_INPUTS_D,
    parameter int N_FBK    = N_FBK_D,
    parameter int MUX_OFS  = MUX_OFS_D,
    parameter int GAP_IDX  = GAP_IDX_D,
    parameter int GAP_ROWS = GAP_ROWS_D,
    parameter int SUM_OFS  = SUM_OFS_D,
    parameter int MIRROR   = MIRROR_D,
    parameter int BASE_W   = 4,
    parameter int WID_W    = 5,
    parameter int ROW_W    = 10,
    parameter int COL_W    = 10,
    parameter int OUT_W    = 6,
    parameter int CNT_W    = 6
) (
    input  phase_t            phase_i,
    input  logic [OUT_W-1:0]  outer_i,
    input  logic [CNT_W-1:0]  inner_i,
    input  logic              neg_i,
    input  logic              odd_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [COL_W-1:0]  mux_col_i,
    input  logic [COL_W-1:0]  pt_col_i,
    input  logic [WID_W-1:0]  width_i,
    output logic [ROW_W-1:0]  row_o,
    output logic              plane_o,
    output logic [COL_W-1:0]  col_o
);
    localparam int FB_W = (N_FBK > 1) ? $clog2(N_FBK) : 1;
    localparam int DR_W = $clog2(BLK_ROWS);

    logic [ROW_W-1:0] row_base;
    logic [ROW_W-1:0] mux_row;
    logic [ROW_W-1:0] lit_row;
    logic [COL_W-1:0] pt_column;
    logic [FB_W-1:0]  fbk_idx;
    logic [DR_W-1:0]  fbk_dr;
    logic             fbk_plane;

    // Purpose: row of an input/mux index, skipping the gap rows above the split.
    function automatic logic [ROW_W-1:0] input_row(input logic [ROW_W-1:0] rb,
                                                   input logic [ROW_W-1:0] idx);
        logic [ROW_W-1:0] r;
        r = rb + ROW_W'(MUX_OFS) + idx;
        if (idx >= ROW_W'(GAP_IDX)) r = r + ROW_W'(GAP_ROWS);
        return r;
    endfunction

    // Purpose: common row base, the two input rows and the mirrored product-term column.
    always_comb begin
        row_base  = ROW_W'(base_i) * ROW_W'(BLK_ROWS);
        mux_row   = input_row(row_base, ROW_W'(outer_i));
        lit_row   = input_row(row_base, ROW_W'(inner_i));
        pt_column = odd_i ? (pt_col_i + COL_W'(MIRROR) - COL_W'(outer_i))
                          : (pt_col_i + COL_W'(outer_i));
        fbk_idx   = FB_W'(inner_i - CNT_W'(N_INPUTS));
    end

    fseq_fbk_map #(
        .BLK_ROWS (BLK_ROWS),
        .N_FBK    (N_FBK),
        .FB_W     (FB_W),
        .DR_W     (DR_W)
    ) fbk_i (
        .fbk_i   (fbk_idx),
        .dr_o    (fbk_dr),
        .plane_o (fbk_plane)
    );

    // Purpose: select the coordinate for the current phase.
    always_comb begin
        row_o   = '0;
        plane_o = 1'b0;
        col_o   = '0;
        unique case (phase_i)
            PH_IMUX: begin
                row_o   = mux_row;
                plane_o = ~odd_i;
                col_o   = mux_col_i + COL_W'(width_i) - COL_W'(1) - COL_W'(inner_i);
            end
            PH_PTRM: begin
                col_o = pt_column;
                if (inner_i < CNT_W'(N_INPUTS)) begin
                    row_o   = lit_row;
                    plane_o = neg_i;
                end else begin
                    row_o   = row_base + ROW_W'(fbk_dr);
                    plane_o = fbk_plane;
                end
            end
            PH_SUMT: begin
                row_o   = row_base + ROW_W'(SUM_OFS) + ROW_W'(inner_i >> 1);
                plane_o = ~inner_i[0];
                col_o   = pt_column;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fuse_addr_seq.sv
// Module: fuse-map address sequencer (top). Captures a block's configuration
// on an accepted start and streams the physical fuse coordinate of each
// array-configuration bit in file order under valid/ready.
// Assumes the consumer may stall indefinitely; start is ignored while busy.
module fuse_addr_seq
    import fuse_seq_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int BASE_W   = 4,
    parameter int WID_W    = 5,
    parameter int ROW_W    = 10,
    parameter int COL_W    = 10,
    parameter int BLK_ROWS = BLK_ROWS_D,
    parameter int N_INPUTS = N_INPUTS_D,
    parameter int N_FBK    = N_FBK_D,
    parameter int N_PTERM  = N_PTERM_D,
    parameter int N_MCELL  = N_MCELL_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  blk_idx_i,
    input  logic [BASE_W-1:0] row_base_i,
    input  logic [COL_W-1:0]  mux_col_i,
    input  logic [COL_W-1:0]  pt_col_i,
    input  logic [WID_W-1:0]  mux_width_i,
    input  logic              coord_ready_i,
    output logic              coord_valid_o,
    output logic [ROW_W-1:0]  coord_row_o,
    output logic              coord_plane_o,
    output logic [COL_W-1:0]  coord_col_o,
    output logic              done_o
);
    localparam int PT_SPAN   = N_INPUTS + N_FBK;
    localparam int OUTER_MAX = (N_INPUTS > N_PTERM) ? N_INPUTS : N_PTERM;
    localparam int OUT_W     = $clog2(OUTER_MAX);
    localparam int SPAN_W    = $clog2(PT_SPAN);
    localparam int CNT_W     = (SPAN_W > WID_W) ? SPAN_W : WID_W;

    phase_t            phase;
    logic [OUT_W-1:0]  outer;
    logic [CNT_W-1:0]  inner;
    logic              neg;
    logic              start_ok;
    logic              accept;

    logic              odd_q;
    logic [BASE_W-1:0] base_q;
    logic [COL_W-1:0]  mux_col_q;
    logic [COL_W-1:0]  pt_col_q;
    logic [WID_W-1:0]  width_q;

    // Purpose: handshake qualifiers.
    always_comb begin
        start_ok = start_i && (phase == PH_IDLE);
        accept   = coord_valid_o && coord_ready_i;
    end

    // Purpose: capture the block configuration when a start is honoured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q     <= 1'b0;
            base_q    <= '0;
            mux_col_q <= '0;
            pt_col_q  <= '0;
            width_q   <= '0;
        end else if (start_ok) begin
            odd_q     <= blk_idx_i[0];
            base_q    <= row_base_i;
            mux_col_q <= mux_col_i;
            pt_col_q  <= pt_col_i;
            width_q   <= mux_width_i;
        end
    end

    fseq_walker #(
        .N_INPUTS (N_INPUTS),
        .N_FBK    (N_FBK),
        .N_PTERM  (N_PTERM),
        .N_MCELL  (N_MCELL),
        .WID_W    (WID_W),
        .OUT_W    (OUT_W),
        .CNT_W    (CNT_W)
    ) walk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok_i (start_ok),
        .skip_mux_i (mux_width_i == '0),
        .width_q_i  (width_q),
        .accept_i   (accept),
        .phase_o    (phase),
        .outer_o    (outer),
        .inner_o    (inner),
        .neg_o      (neg),
        .done_o     (done_o)
    );

    fseq_coord #(
        .BLK_ROWS (BLK_ROWS),
        .N_INPUTS (N_INPUTS),
        .N_FBK    (N_FBK),
        .BASE_W   (BASE_W),
        .WID_W    (WID_W),
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .OUT_W    (OUT_W),
        .CNT_W    (CNT_W)
    ) coord_i (
        .phase_i   (phase),
        .outer_i   (outer),
        .inner_i   (inner),
        .neg_i     (neg),
        .odd_i     (odd_q),
        .base_i    (base_q),
        .mux_col_i (mux_col_q),
        .pt_col_i  (pt_col_q),
        .width_i   (width_q),
        .row_o     (coord_row_o),
        .plane_o   (coord_plane_o),
        .col_o     (coord_col_o)
    );

    assign coord_valid_o = (phase != PH_IDLE);
endmodule

// File: rtl/fuse_addr_seq_chk.sv
// Module: protocol checker for the sequencer, bound to every instance.
// Assumes only top-level port behaviour; no internal state is inspected.
module fuse_addr_seq_chk #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             coord_ready_i,
    input logic             coord_valid_o,
    input logic [ROW_W-1:0] coord_row_o,
    input logic             coord_plane_o,
    input logic [COL_W-1:0] coord_col_o,
    input logic             done_o
);
    // R8
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coord_valid_o && !coord_ready_i |=> coord_valid_o && $stable(coord_row_o)
            && $stable(coord_plane_o) && $stable(coord_col_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(coord_valid_o && coord_ready_i) && !coord_valid_o);

    // R1
    launch_by_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coord_valid_o) |-> $past(start_i));

    // R8
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coord_valid_o) |-> done_o);
endmodule

bind fuse_addr_seq fuse_addr_seq_chk #(
    .ROW_W (ROW_W),
    .COL_W (COL_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .coord_ready_i (coord_ready_i),
    .coord_valid_o (coord_valid_o),
    .coord_row_o   (coord_row_o),
    .coord_plane_o (coord_plane_o),
    .coord_col_o   (coord_col_o),
    .done_o        (done_o)
);

// File: tb/fuse_addr_seq_tb_top.sv
// Bench: builds the expected coordinate stream from the requirements and
// compares every accepted beat under random back-pressure.
module fuse_addr_seq_tb_top;
    localparam int IDX_W  = 4;
    localparam int BASE_W = 4;
    localparam int WID_W  = 5;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [IDX_W-1:0]  blk_idx_i = '0;
    logic [BASE_W-1:0] row_base_i = '0;
    logic [COL_W-1:0]  mux_col_i = '0;
    logic [COL_W-1:0]  pt_col_i = '0;
    logic [WID_W-1:0]  mux_width_i = '0;
    logic              coord_ready_i = 1'b0;
    logic              coord_valid_o;
    logic [ROW_W-1:0]  coord_row_o;
    logic              coord_plane_o;
    logic [COL_W-1:0]  coord_col_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;

    int    exp_row[$];
    int    exp_pl[$];
    int    exp_col[$];
    string exp_tag[$];

    always #2.5 clk = ~clk;

    fuse_addr_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .blk_idx_i     (blk_idx_i),
        .row_base_i    (row_base_i),
        .mux_col_i     (mux_col_i),
        .pt_col_i      (pt_col_i),
        .mux_width_i   (mux_width_i),
        .coord_ready_i (coord_ready_i),
        .coord_valid_o (coord_valid_o),
        .coord_row_o   (coord_row_o),
        .coord_plane_o (coord_plane_o),
        .coord_col_o   (coord_col_o),
        .done_o        (done_o)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    function automatic int in_row(input int base, input int j);
        return base * 52 + 2 + j + ((j >= 20) ? 8 : 0);
    endfunction

    function automatic int pt_column(input int idx, input int ptc, input int p);
        return ((idx % 2) == 1) ? ptc + 95 - p : ptc + p;
    endfunction

    // Expected stream per R2..R6, in R7 order.
    task automatic build_expected(input int idx, input int base, input int mc,
                                  input int ptc, input int w);
        int fdr[8] = '{0, 0, 1, 1, 50, 50, 51, 51};
        int fpl[8] = '{1, 0, 1, 0, 0, 1, 0, 1};
        exp_row.delete(); exp_pl.delete(); exp_col.delete(); exp_tag.delete();
        for (int j = 0; j < 40; j++)
            for (int k = 0; k < w; k++) begin
                exp_row.push_back(in_row(base, j));
                exp_pl.push_back(((idx % 2) == 1) ? 0 : 1);
                exp_col.push_back(mc + w - 1 - k);
                exp_tag.push_back((j >= 20) ? "R3" : "R2");
            end
        for (int p = 0; p < 48; p++) begin
            for (int i = 0; i < 40; i++)
                for (int n = 0; n < 2; n++) begin
                    exp_row.push_back(in_row(base, i));
                    exp_pl.push_back(n);
                    exp_col.push_back(pt_column(idx, ptc, p));
                    exp_tag.push_back((i >= 20) ? "R3" : "R4");
                end
            for (int f = 0; f < 8; f++) begin
                exp_row.push_back(base * 52 + fdr[f]);
                exp_pl.push_back(fpl[f]);
                exp_col.push_back(pt_column(idx, ptc, p));
                exp_tag.push_back("R5");
            end
        end
        for (int p = 0; p < 48; p++)
            for (int m = 0; m < 16; m++) begin
                exp_row.push_back(base * 52 + 22 + m / 2);
                exp_pl.push_back(1 - (m % 2));
                exp_col.push_back(pt_column(idx, ptc, p));
                exp_tag.push_back("R6");
            end
    endtask

    task automatic run_seq(input int idx, input int base, input int mc, input int ptc,
                           input int w, input int ready_pct, input bit inject);
        int  total;
        int  n;
        int  err0;
        bit  acc;
        bit  injected;
        build_expected(idx, base, mc, ptc, w);
        total = 40 * w + 4992;
        blk_idx_i   = IDX_W'(idx);
        row_base_i  = BASE_W'(base);
        mux_col_i   = COL_W'(mc);
        pt_col_i    = COL_W'(ptc);
        mux_width_i = WID_W'(w);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        err0 = errors;
        n = 0;
        injected = 1'b0;
        while (n < total) begin
            check(coord_valid_o && !done_o && int'(coord_row_o) == exp_row[n]
                  && int'(coord_plane_o) == exp_pl[n] && int'(coord_col_o) == exp_col[n],
                  exp_tag[n],
                  $sformatf("beat %0d act v%0d d%0d (%0d,%0d,%0d) exp (%0d,%0d,%0d)",
                            n, coord_valid_o, done_o, coord_row_o, coord_plane_o,
                            coord_col_o, exp_row[n], exp_pl[n], exp_col[n]));
            coord_ready_i = (($urandom % 100) < 32'(ready_pct));
            if (inject && !injected && n >= total / 3) begin
                injected    = 1'b1;
                start_i     = 1'b1;
                blk_idx_i   = ~blk_idx_i;
                row_base_i  = row_base_i + 1'b1;
                mux_col_i   = mux_col_i + 10'd7;
                pt_col_i    = pt_col_i + 10'd3;
                mux_width_i = WID_W'(w + 1);
            end
            acc = coord_ready_i;
            @(negedge clk);
            start_i = 1'b0;
            if (acc) n++;
        end
        coord_ready_i = 1'b0;
        // R7 and R9: done exactly after beat count 40*W+4992
        check(done_o && !coord_valid_o, "R9",
              $sformatf("after %0d beats act done%0d valid%0d exp done1 valid0",
                        total, done_o, coord_valid_o));
        @(negedge clk);
        check(!done_o && !coord_valid_o, "R9",
              $sformatf("pulse width act done%0d valid%0d exp done0 valid0",
                        done_o, coord_valid_o));
        if (inject)
            check(errors == err0, "R10",
                  $sformatf("run after ignored start act errs %0d exp 0", errors - err0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog act timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!coord_valid_o && !done_o, "R1",
              $sformatf("reset act v%0d d%0d exp v0 d0", coord_valid_o, done_o));
        run_seq(0, 0, 100, 300, 5, 100, 1'b0);      // R2 R4 R5 R6 even, no stall
        run_seq(3, 2, 40, 500, 8, 60, 1'b1);        // R10 odd block with stray start
        run_seq(6, 1, 20, 200, 0, 70, 1'b0);        // R11 zero width
        run_seq(1, 15, 900, 900, 31, 45, 1'b0);     // R3 R8 max base and width
        for (int r = 0; r < 2; r++)
            run_seq(int'($urandom % 16), int'($urandom % 16), int'($urandom % 900),
                    int'($urandom % 900), int'($urandom % 32), 30 + int'($urandom % 60), 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule